// File: doc/BRIEF.md
# Change-of-Flow Trace Buffer

This block keeps a compressed execution history inside the chip. It does not record every bus cycle. It watches the processor's address bus and keeps only the destination addresses of control transfers that cannot be worked out from the program image: taken conditional branches and indirect subroutine calls. A host debugger reads the stored words back later and fills in the straight-line code between them. Bus cycles that the processor marks as free are never stored. A small ring of eight 16-bit words holds the history.

Writing the arm control starts a run and picks one of two capture windows. In begin-trigger mode the buffer stays empty until the trigger pulse arrives. It then records until it holds eight entries and stops by itself, raising a full flag. In end-trigger mode recording starts at once and the ring overwrites its oldest word. The trigger freezes it, so it keeps the eight most recent transfers that led up to the trigger. The host reads the oldest stored word on a show-ahead data port and pops one word per strobe.

The controller has five states. ST_IDLE is the state after reset. ST_WAIT_TRIG means armed in begin mode. ST_CAPTURE means recording after the trigger. ST_PRE_TRIG means recording in end mode. ST_FROZEN means the run is over. The transitions are: arm (any state to ST_WAIT_TRIG or ST_PRE_TRIG, chosen by end_mode), trigger-seen (ST_WAIT_TRIG to ST_CAPTURE), eighth-write (ST_CAPTURE to ST_FROZEN), and trigger-freeze (ST_PRE_TRIG to ST_FROZEN).

Top module: `cof_trace_fifo`

## Requirements
- R1: After reset, count is 0, full is 0, rd_data is 0 and the controller is in ST_IDLE, so no event is stored until arm is written.
- R2: A cycle is a storable event only when bus_valid=1, cof_taken=1 and bus_free=0. Any other combination, including a free cycle with cof_taken=1, stores nothing.
- R3: arm=1 empties the buffer and clears full on the next edge, whatever state the block is in. It samples end_mode (0 = begin-trigger, 1 = end-trigger). It takes priority over trig, events and pops in the same cycle, and an event in that cycle is not stored.
- R4: In begin-trigger mode, events before the trigger are not stored, and neither is an event in the same cycle as trig. Storing starts with the first event after the trigger cycle.
- R5: In begin-trigger mode, bus_addr of the first eight events after the trigger is stored in arrival order. full rises after the edge that writes the eighth entry. Later events are ignored until the next arm.
- R6: full, once set, stays at 1 while entries are popped, until the next arm.
- R7: In end-trigger mode, every event from the arm onward is stored. With eight entries held, a new event drops the oldest one and count stays 8. An event in the trig cycle is still stored. After that cycle the buffer is frozen, and full stays 0 in this mode.
- R8: While count>0, rd_data shows the oldest stored entry. In ST_IDLE or ST_FROZEN, rd_pop=1 removes that entry and lowers count by one at the next edge.
- R9: With count=0, rd_data reads 0 and rd_pop changes nothing.
- R10: rd_pop has no effect in ST_WAIT_TRIG, ST_CAPTURE or ST_PRE_TRIG.
- R11: count is 4 bits wide and always lies in the range 0 to 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| arm | input | 1 | Pulse: clear the buffer and start a run |
| end_mode | input | 1 | Window select sampled at arm: 0 begin-trigger, 1 end-trigger |
| trig | input | 1 | Trigger pulse from the trigger unit |
| bus_valid | input | 1 | Bus cycle strobe |
| bus_free | input | 1 | Processor marks the cycle as free |
| cof_taken | input | 1 | Taken branch or indirect jump in this cycle |
| bus_addr | input | 16 | Destination address of the transfer |
| rd_pop | input | 1 | Host pops the oldest entry |
| rd_data | output | 16 | Oldest stored entry, or 0 when empty |
| count | output | 4 | Number of stored entries |
| full | output | 1 | Begin-trigger run filled the buffer |

## Verification
The bench compares the block, cycle by cycle, against a queue-based model, using seeded random stimulus mixed with directed corner cases. The directed cases target the following mistakes:
- Storing an event that arrives in the trigger cycle in begin mode would leave one entry too many.
- Keeping free cycles that carry a change-of-flow flag would fill the ring with junk.
- Counting past eight or failing to drop the oldest entry in end mode would show up as a wrong count or a wrong pop order.
- Letting pops act during recording, or clearing full on a pop, would change count or the flag at once.
- Popping an empty buffer must leave count at zero and rd_data at zero.

// File: rtl/cof_trace_pkg.sv
package cof_trace_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_TRIG,
        ST_CAPTURE,
        ST_PRE_TRIG,
        ST_FROZEN
    } trace_state_t;
endpackage

// File: rtl/cof_event_qual.sv
module cof_event_qual (
    input  logic bus_valid,
    input  logic bus_free,
    input  logic cof_taken,
    output logic evt
);
    // A storable event: a real bus cycle that carries a control transfer
    always_comb begin
        evt = bus_valid & cof_taken & ~bus_free;
    end
endmodule

// File: rtl/cof_trace_ctrl.sv
module cof_trace_ctrl
    import cof_trace_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             end_mode,
    input  logic             trig,
    input  logic             evt,
    input  logic [CNT_W-1:0] level,
    output logic             rec_en,
    output logic             wrap_en,
    output logic             pop_ok,
    output logic             full
);
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(DEPTH - 1);

    trace_state_t state_q, state_d;
    logic         fill_done;

    always_comb begin
        fill_done = (state_q == ST_CAPTURE) && evt && (level == LAST_SLOT);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (arm) begin
            state_d = end_mode ? ST_PRE_TRIG : ST_WAIT_TRIG;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_WAIT_TRIG: if (trig) state_d = ST_CAPTURE;
                ST_CAPTURE:   if (fill_done) state_d = ST_FROZEN;
                ST_PRE_TRIG:  if (trig) state_d = ST_FROZEN;
                ST_FROZEN:    state_d = ST_FROZEN;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
        end else if (arm) begin
            full <= 1'b0;
        end else if (fill_done) begin
            full <= 1'b1;
        end
    end

    // outputs decoded from state
    always_comb begin
        rec_en  = 1'b0;
        wrap_en = 1'b0;
        pop_ok  = 1'b0;
        unique case (state_q)
            ST_IDLE:      pop_ok = 1'b1;
            ST_WAIT_TRIG: ;
            ST_CAPTURE:   rec_en = 1'b1;
            ST_PRE_TRIG: begin
                rec_en  = 1'b1;
                wrap_en = 1'b1;
            end
            ST_FROZEN:    pop_ok = 1'b1;
            default:      ;
        endcase
    end

    // R6
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !arm) |=> full);

    // R5
    full_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (state_q == ST_FROZEN));
endmodule

// File: rtl/cof_trace_store.sv
module cof_trace_store #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    parameter int PTR_W  = 3,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr,
    input  logic              wrap,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  level,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [CNT_W-1:0] CAP      = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              at_cap, do_wr, do_drop, do_pop;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        at_cap  = (level == CAP);
        do_wr   = wr && (!at_cap || wrap);
        do_drop = do_wr && at_cap;
        do_pop  = pop && (level != '0) && !do_wr;
    end

    always_ff @(posedge clk) begin
        if (do_wr && !clear) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_wr) wr_ptr <= nxt(wr_ptr);
            if (do_drop || do_pop) rd_ptr <= nxt(rd_ptr);
            if (do_wr && !do_drop) level <= level + 1'b1;
            else if (do_pop) level <= level - 1'b1;
        end
    end

    always_comb begin
        rdata = (level == '0) ? '0 : mem[rd_ptr];
    end

    // R11
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CAP);

    // R9
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && level == '0 && !clear && !wr) |=> (level == '0));
endmodule

// File: rtl/cof_trace_fifo.sv
module cof_trace_fifo #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      arm,
    input  logic                      end_mode,
    input  logic                      trig,
    input  logic                      bus_valid,
    input  logic                      bus_free,
    input  logic                      cof_taken,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      rd_pop,
    output logic [ADDR_W-1:0]         rd_data,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                      full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic evt, rec_en, wrap_en, pop_ok;

    cof_event_qual u_qual (
        .bus_valid (bus_valid),
        .bus_free  (bus_free),
        .cof_taken (cof_taken),
        .evt       (evt)
    );

    cof_trace_ctrl #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .end_mode (end_mode),
        .trig     (trig),
        .evt      (evt),
        .level    (count),
        .rec_en   (rec_en),
        .wrap_en  (wrap_en),
        .pop_ok   (pop_ok),
        .full     (full)
    );

    cof_trace_store #(
        .DEPTH  (DEPTH),
        .DATA_W (ADDR_W),
        .PTR_W  (PTR_W),
        .CNT_W  (CNT_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (arm),
        .wr    (evt && rec_en),
        .wrap  (wrap_en),
        .pop   (rd_pop && pop_ok),
        .wdata (bus_addr),
        .level (count),
        .rdata (rd_data)
    );

    // R3
    arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (count == '0 && !full));

    // R2
    free_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_en && bus_free && !arm) |=> $stable(count));

    // R10
    busy_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && !pop_ok && !arm && !evt) |=> $stable(count));

    // R8
    pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && pop_ok && count != '0 && !arm) |=> (count == $past(count) - 1'b1));
endmodule

// File: tb/cof_trace_fifo_tb.sv
module cof_trace_fifo_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 0, end_mode = 0, trig = 0;
    logic        bus_valid = 0, bus_free = 0, cof_taken = 0, rd_pop = 0;
    logic [15:0] bus_addr = '0;
    logic [15:0] rd_data;
    logic [3:0]  count;
    logic        full;

    always #2 clk = ~clk;

    cof_trace_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .end_mode(end_mode), .trig(trig),
        .bus_valid(bus_valid), .bus_free(bus_free), .cof_taken(cof_taken),
        .bus_addr(bus_addr), .rd_pop(rd_pop), .rd_data(rd_data),
        .count(count), .full(full)
    );

    int checks = 0;
    int errors = 0;

    // reference model: 0 idle, 1 wait, 2 capture, 3 pre-trigger, 4 frozen
    logic [15:0] mq[$];
    int          mst = 0;
    bit          mfull = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int head();
        return (mq.size() > 0) ? int'(mq[0]) : 0;
    endfunction

    function automatic void model_edge();
        bit ev;
        ev = bus_valid && cof_taken && !bus_free;
        if (arm) begin
            mq.delete();
            mfull = 0;
            mst = end_mode ? 3 : 1;
        end else begin
            case (mst)
                1: if (trig) mst = 2;
                2: if (ev) begin
                       mq.push_back(bus_addr);
                       if (mq.size() == 8) begin mfull = 1; mst = 4; end
                   end
                3: begin
                       if (ev) begin
                           if (mq.size() == 8) void'(mq.pop_front());
                           mq.push_back(bus_addr);
                       end
                       if (trig) mst = 4;
                   end
                default: if (rd_pop && mq.size() > 0) void'(mq.pop_front());
            endcase
        end
    endfunction

    task automatic step(input bit a, input bit m, input bit t, input bit v,
                        input bit f, input bit c, input logic [15:0] ad, input bit p);
        arm = a; end_mode = m; trig = t; bus_valid = v;
        bus_free = f; cof_taken = c; bus_addr = ad; rd_pop = p;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(int'(count) == mq.size(), "R11 count", count, mq.size());
        chk(full == mfull, "R6 full", full, mfull);
        chk(int'(rd_data) == head(), "R8 rd_data", rd_data, head());
    endtask

    task automatic ev(input logic [15:0] ad);
        step(0, 0, 0, 1, 0, 1, ad, 0);
    endtask

    task automatic pop();
        step(0, 0, 0, 0, 0, 0, 16'h0, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(count == 0, "R1 count", count, 0);
        chk(full == 0, "R1 full", full, 0);
        chk(rd_data == 0, "R1 rd_data", rd_data, 0);
        ev(16'h1234);
        chk(count == 0, "R1 idle ignores events", count, 0);

        // begin-trigger run
        step(1, 0, 0, 0, 0, 0, 16'h0, 0);
        ev(16'h1111);
        chk(count == 0, "R4 pre-trigger event", count, 0);
        step(0, 0, 1, 1, 0, 1, 16'h2222, 0);
        chk(count == 0, "R4 trigger-cycle event", count, 0);
        ev(16'hA000);
        chk(count == 1 && rd_data == 16'hA000, "R4 first capture", rd_data, 16'hA000);
        step(0, 0, 0, 1, 1, 1, 16'hDEAD, 0);
        chk(count == 1, "R2 free cycle", count, 1);
        step(0, 0, 0, 1, 0, 0, 16'hDEAD, 0);
        chk(count == 1, "R2 no cof", count, 1);
        step(0, 0, 0, 0, 0, 1, 16'hDEAD, 0);
        chk(count == 1, "R2 no valid", count, 1);
        pop();
        chk(count == 1 && rd_data == 16'hA000, "R10 pop in capture", count, 1);
        for (int i = 1; i < 7; i++) ev(16'hA000 + 16'(i));
        chk(full == 0 && count == 7, "R5 seven held", count, 7);
        ev(16'hA007);
        chk(full == 1 && count == 8, "R5 full after eighth", full, 1);
        ev(16'hA0FF);
        chk(count == 8, "R5 later ignored", count, 8);
        for (int i = 0; i < 8; i++) begin
            chk(rd_data == 16'hA000 + 16'(i), "R8 pop order", rd_data, 16'hA000 + i);
            pop();
            chk(full == 1, "R6 full holds", full, 1);
        end
        chk(count == 0 && rd_data == 0, "R9 empty reads zero", rd_data, 0);
        pop();
        chk(count == 0 && rd_data == 0, "R9 empty pop", count, 0);

        // end-trigger run
        step(1, 1, 0, 1, 0, 1, 16'h5555, 0);
        chk(count == 0 && full == 0, "R3 arm clears, event dropped", count, 0);
        for (int i = 0; i < 12; i++) ev(16'hB000 + 16'(i));
        chk(count == 8 && rd_data == 16'hB004, "R7 overwrite oldest", rd_data, 16'hB004);
        pop();
        chk(count == 8, "R10 pop in pre-trigger", count, 8);
        step(0, 0, 1, 1, 0, 1, 16'hBEEF, 0);
        chk(rd_data == 16'hB005 && full == 0, "R7 trigger-cycle stored", rd_data, 16'hB005);
        ev(16'hC000);
        chk(count == 8 && rd_data == 16'hB005, "R7 frozen", rd_data, 16'hB005);
        for (int i = 0; i < 7; i++) pop();
        chk(count == 1 && rd_data == 16'hBEEF, "R7 newest last", rd_data, 16'hBEEF);

        // arm from frozen with data
        step(1, 0, 1, 0, 0, 0, 16'h0, 1);
        chk(count == 0 && full == 0, "R3 re-arm", count, 0);
        ev(16'h7777);
        chk(count == 0, "R3 trig ignored during arm", count, 0);

        // random mix
        void'($urandom(32'h00C0FFEE));
        for (int n = 0; n < 4000; n++) begin
            step(($urandom() % 64) == 0, $urandom() % 2, ($urandom() % 16) == 0,
                 ($urandom() % 4) != 0, ($urandom() % 4) == 0, $urandom() % 2,
                 16'($urandom()), ($urandom() % 4) == 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule